// File: doc/BRIEF.md
# Serial Line Encoder and Decoder with NRZI Coding and Bit Stuffing

This block turns a stream of single bits into the line signals of a half-duplex serial link, and turns the received line back into bits. On the transmit side, the first data bit offered on an idle link starts a packet. The block first sends an eight-bit synchronisation pattern, then takes the offered bits one per bit time. After six ones in a row it adds a zero so the line keeps changing. Each resulting bit is coded by transitions: a zero flips the line level and a one leaves it alone. The line is driven as a complementary pair together with a driver enable. The packet ends at the first bit time in which no data bit is offered.

The receive side samples one line once per bit time while its enable input is high. It turns level changes back into bits and drops the zero that follows six ones. When a seventh one arrives where that zero was due, it raises an error pulse. Both sides advance only on clock cycles where `bit_en` is high, so one strobe is one bit time. The transmit outputs can be looped straight back to the receive inputs.

Top module: `nrzi_link_codec`

## Requirements
- R1: After reset, `tx_oe` is 0, `tx_dp` is 1, `tx_dm` is 0, `tx_ready` is 0, and `rx_valid` and `rx_stuff_err` are 0.
- R2: Each transmitted bit updates the line at a `bit_en` edge. A 0 inverts `tx_dp` and a 1 leaves it unchanged. The line never changes on a cycle without `bit_en`.
- R3: When `tx_valid` is seen on an idle link at a `bit_en` edge, a packet starts. The first eight bit times carry the pattern 0,0,0,0,0,0,0,1 in that order (the byte 80h, least significant bit first). `tx_ready` stays 0 during these bit times, and afterwards it is 1 in every data bit time that is not a stuffed one.
- R4: After six consecutive ones on the wire, with the final one of the sync pattern counted, one zero is inserted and the run count restarts.
- R5: `tx_ready` is 0 throughout the bit time in which a stuffed zero is sent, so no data bit is taken in that slot.
- R6: If the sixth consecutive one is the last data bit, the stuffed zero is still sent before the packet ends.
- R7: In the first data bit time with `tx_valid` low and no stuffed bit due, `tx_oe` drops and the line returns to idle (`tx_dp` = 1, `tx_dm` = 0). While `tx_oe` is 0, `tx_dp` is 1.
- R8: `tx_dm` is always the complement of `tx_dp`.
- R9: While `rx_en` is high, each `bit_en` edge decodes one bit: 1 if `rx_dp` equals the previous sample, else 0. The first previous level is 1. The bit appears on `rx_bit` with `rx_valid` high for one clock after that edge.
- R10: A decoded 0 that follows six decoded ones is dropped and gives no `rx_valid`.
- R11: A decoded 1 that follows six decoded ones gives a one-clock `rx_stuff_err` pulse and no `rx_valid`. Counting of ones then restarts from zero.
- R12: While `rx_en` is low, the receiver resets its previous level to 1 and its run count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe marking a bit time |
| tx_valid | input | 1 | A data bit is offered |
| tx_bit | input | 1 | Offered data bit |
| tx_ready | output | 1 | Offered bit is taken at the next `bit_en` edge |
| tx_dp | output | 1 | Positive line level |
| tx_dm | output | 1 | Negative line level, complement of `tx_dp` |
| tx_oe | output | 1 | Line driver enable |
| rx_en | input | 1 | Receive line is active |
| rx_dp | input | 1 | Received line level |
| rx_valid | output | 1 | Decoded bit is present |
| rx_bit | output | 1 | Decoded bit |
| rx_stuff_err | output | 1 | Seventh consecutive one was received |

## Verification
The hardest case to reach is the receive stuffing error. A correct transmitter always breaks a run of six ones, so a loopback test can never produce it. The bench therefore switches the receive inputs away from the transmitter and drives line levels directly: six held bit times, then a seventh. It also checks the stuffed zero that comes after the last data bit, using a directed packet whose data completes a run of six ones together with the sync pattern's final one. Random packets are weighted towards ones so that stuffing occurs in many positions.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SYNC = 2'd1,
    TX_DATA = 2'd2
  } tx_state_e;

  // Line level after sending bit b from level cur: zero flips, one holds.
  function automatic logic nrzi_level(input logic cur, input logic b);
    return b ? cur : ~cur;
  endfunction

  // Bit recovered from two successive line samples.
  function automatic logic nrzi_bit(input logic prev, input logic now);
    return (prev == now);
  endfunction

endpackage

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx #(
  parameter int          RUN_LEN      = 6,
  parameter int          SYNC_W       = 8,
  parameter logic [7:0]  SYNC_PATTERN = 8'h80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic emit,
  output logic wire_bit,
  output logic go_idle,
  output logic stuff_slot
);
  import nrzi_pkg::*;

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam int IW = (SYNC_W > 1) ? $clog2(SYNC_W) : 1;
  localparam logic [CW-1:0] RUN_MAX  = CW'(RUN_LEN);
  localparam logic [IW-1:0] SYNC_END = IW'(SYNC_W - 1);

  tx_state_e     state_q, state_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [CW-1:0] ones_q, ones_n;

  function automatic logic [CW-1:0] run_after(input logic [CW-1:0] c, input logic b);
    return b ? c + 1'b1 : '0;
  endfunction

  assign stuff_slot = (state_q == TX_DATA) && (ones_q == RUN_MAX);
  assign tx_ready   = (state_q == TX_DATA) && !stuff_slot;

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    ones_n   = ones_q;
    emit     = 1'b0;
    wire_bit = 1'b0;
    go_idle  = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (bit_en && tx_valid) begin
          emit     = 1'b1;
          wire_bit = SYNC_PATTERN[0];
          ones_n   = run_after('0, SYNC_PATTERN[0]);
          if (SYNC_W > 1) begin
            state_n = TX_SYNC;
            idx_n   = IW'(1);
          end else begin
            state_n = TX_DATA;
          end
        end
      end
      TX_SYNC: begin
        if (bit_en) begin
          emit     = 1'b1;
          wire_bit = SYNC_PATTERN[idx_q];
          ones_n   = run_after(ones_q, SYNC_PATTERN[idx_q]);
          if (idx_q == SYNC_END) begin
            state_n = TX_DATA;
            idx_n   = '0;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      TX_DATA: begin
        if (bit_en) begin
          if (stuff_slot) begin
            emit     = 1'b1;
            wire_bit = 1'b0;
            ones_n   = '0;
          end else if (tx_valid) begin
            emit     = 1'b1;
            wire_bit = tx_bit;
            ones_n   = run_after(ones_q, tx_bit);
          end else begin
            go_idle = 1'b1;
            ones_n  = '0;
            state_n = TX_IDLE;
          end
        end
      end
      default: state_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      ones_q  <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      ones_q  <= ones_n;
    end
  end

  AST_TX_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RUN_MAX);  // R4

  AST_TX_NO_TAKE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE) |-> !tx_ready);  // R3

endmodule

// File: rtl/nrzi_line_drv.sv
module nrzi_line_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic emit,
  input  logic wire_bit,
  input  logic go_idle,
  output logic tx_dp,
  output logic tx_dm,
  output logic tx_oe
);
  import nrzi_pkg::*;

  logic dp_q, dm_q, oe_q;
  logic next_level;

  assign next_level = nrzi_level(dp_q, wire_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q <= 1'b1;
      dm_q <= 1'b0;
      oe_q <= 1'b0;
    end else if (bit_en && go_idle) begin
      dp_q <= 1'b1;
      dm_q <= 1'b0;
      oe_q <= 1'b0;
    end else if (bit_en && emit) begin
      dp_q <= next_level;
      dm_q <= ~next_level;
      oe_q <= 1'b1;
    end
  end

  assign tx_dp = dp_q;
  assign tx_dm = dm_q;
  assign tx_oe = oe_q;

  AST_ZERO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && emit && !go_idle && !wire_bit) |=> (dp_q != $past(dp_q)));  // R2

  AST_ONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && emit && !go_idle && wire_bit) |=> $stable(dp_q));  // R2

  AST_QUIET_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(dp_q));  // R2

  AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    dp_q != dm_q);  // R8

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> dp_q);  // R7

endmodule

// File: rtl/nrzi_destuff_rx.sv
module nrzi_destuff_rx #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_en,
  input  logic rx_dp,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_stuff_err,
  output logic drop_evt,
  output logic err_evt
);
  import nrzi_pkg::*;

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic          prev_q;
  logic [CW-1:0] run_q;
  logic          valid_q, bit_q, err_q;
  logic          raw_bit, at_limit, strobe;

  assign strobe   = rx_en && bit_en;
  assign raw_bit  = nrzi_bit(prev_q, rx_dp);
  assign at_limit = (run_q == RUN_MAX);
  assign drop_evt = strobe && at_limit && !raw_bit;
  assign err_evt  = strobe && at_limit && raw_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      run_q   <= '0;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (!rx_en) begin
        prev_q <= 1'b1;
        run_q  <= '0;
      end else if (bit_en) begin
        prev_q <= rx_dp;
        if (at_limit) begin
          run_q <= '0;
          err_q <= raw_bit;
        end else begin
          valid_q <= 1'b1;
          bit_q   <= raw_bit;
          run_q   <= raw_bit ? run_q + 1'b1 : '0;
        end
      end
    end
  end

  assign rx_valid     = valid_q;
  assign rx_bit       = bit_q;
  assign rx_stuff_err = err_q;

  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && err_q));  // R11

  AST_RX_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (!valid_q && !err_q));  // R10

  AST_RX_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (err_q && run_q == '0));  // R11

  AST_RX_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);  // R10

  AST_RX_OFF_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (prev_q && run_q == '0));  // R12

endmodule

// File: rtl/nrzi_link_codec.sv
module nrzi_link_codec #(
  parameter int         RUN_LEN      = 6,
  parameter int         SYNC_W       = 8,
  parameter logic [7:0] SYNC_PATTERN = 8'h80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic tx_dp,
  output logic tx_dm,
  output logic tx_oe,
  input  logic rx_en,
  input  logic rx_dp,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_stuff_err
);

  logic emit, wire_bit, go_idle, stuff_slot;
  logic drop_evt, err_evt;

  nrzi_stuff_tx #(
    .RUN_LEN     (RUN_LEN),
    .SYNC_W      (SYNC_W),
    .SYNC_PATTERN(SYNC_PATTERN)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .tx_valid  (tx_valid),
    .tx_bit    (tx_bit),
    .tx_ready  (tx_ready),
    .emit      (emit),
    .wire_bit  (wire_bit),
    .go_idle   (go_idle),
    .stuff_slot(stuff_slot)
  );

  nrzi_line_drv u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .emit    (emit),
    .wire_bit(wire_bit),
    .go_idle (go_idle),
    .tx_dp   (tx_dp),
    .tx_dm   (tx_dm),
    .tx_oe   (tx_oe)
  );

  nrzi_destuff_rx #(
    .RUN_LEN(RUN_LEN)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .rx_en       (rx_en),
    .rx_dp       (rx_dp),
    .rx_valid    (rx_valid),
    .rx_bit      (rx_bit),
    .rx_stuff_err(rx_stuff_err),
    .drop_evt    (drop_evt),
    .err_evt     (err_evt)
  );

  AST_STUFF_FORCES_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_slot) |=> (tx_dp != $past(tx_dp) && tx_oe));  // R4

  AST_STUFF_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_slot |-> !tx_ready);  // R5

  AST_STUFF_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_slot) |=> tx_oe);  // R6

endmodule

// File: tb/nrzi_link_codec_tb.sv
module nrzi_link_codec_tb;

  localparam logic [7:0] SYNC = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b0;
  logic tx_ready, tx_dp, tx_dm, tx_oe;
  logic rx_valid, rx_bit, rx_stuff_err;
  logic lb = 1'b1;
  logic drv_en = 1'b0;
  logic drv_dp = 1'b1;
  logic rx_en_w, rx_dp_w;

  assign rx_en_w = lb ? tx_oe : drv_en;
  assign rx_dp_w = lb ? tx_dp : drv_dp;

  always #2 clk = ~clk;

  nrzi_link_codec u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .tx_dp(tx_dp), .tx_dm(tx_dm), .tx_oe(tx_oe),
    .rx_en(rx_en_w), .rx_dp(rx_dp_w),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_stuff_err(rx_stuff_err)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic d [0:63];
  int   n;
  logic exp_w [0:127];
  logic exp_s [0:127];
  int   total;
  logic rxb [0:127];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic b, input logic st, inout int ones);
    exp_w[total] = b;
    exp_s[total] = st;
    total++;
    ones = b ? ones + 1 : 0;
  endtask

  // Expected wire sequence: sync then data, a zero after each run of six ones.
  task automatic build_expected();
    int ones = 0;
    total = 0;
    for (int i = 0; i < 8 + n; i++) begin
      logic b;
      b = (i < 8) ? SYNC[i] : d[i-8];
      push(b, 1'b0, ones);
      if (ones == 6) push(1'b0, 1'b1, ones);
    end
  endtask

  task automatic send_packet();
    int w = 0;
    int p = 0;
    int rxn = 0;
    logic prev_dp = 1'b1;
    logic rdy, wb;
    string lbl;
    lb = 1'b1;
    build_expected();
    for (int s = 0; s < total + 2; s++) begin
      tx_valid = (p < n);
      tx_bit   = (p < n) ? d[p] : 1'b0;
      bit_en   = 1'b1;
      #1;
      rdy = tx_ready;
      if (w < total) begin
        lbl = (w < 8) ? "R3" : (exp_s[w] ? "R5" : "R3");
        chk(rdy == (w >= 8 && !exp_s[w]), lbl, rdy, (w >= 8 && !exp_s[w]));
      end
      @(posedge clk);
      @(negedge clk);
      bit_en = 1'b0;
      if (tx_valid && rdy) p++;
      tx_valid = 1'b0;
      if (rx_valid) begin rxb[rxn] = rx_bit; rxn++; end
      chk(!rx_stuff_err, "R11", rx_stuff_err, 0);
      if (w < total) begin
        chk(tx_oe == 1'b1, "R7", tx_oe, 1);
        wb = (tx_dp == prev_dp);
        lbl = exp_s[w] ? ((w == total - 1) ? "R6" : "R4") : "R2";
        chk(wb == exp_w[w], lbl, wb, exp_w[w]);
        chk(tx_dm == !tx_dp, "R8", tx_dm, !tx_dp);
        prev_dp = tx_dp;
        w++;
      end else if (s == total) begin
        chk(!tx_oe && tx_dp && !tx_dm, "R7", {tx_oe, tx_dp, tx_dm}, 3'b010);
      end
      @(negedge clk);
    end
    chk(p == n, "R3", p, n);
    lbl = (total > 8 + n) ? "R10" : "R9";
    chk(rxn == 8 + n, lbl, rxn, 8 + n);
    for (int i = 0; i < 8 + n && i < rxn; i++) begin
      logic e;
      e = (i < 8) ? SYNC[i] : d[i-8];
      chk(rxb[i] == e, lbl, rxb[i], e);
    end
  endtask

  task automatic rx_slot(input logic en, input logic lvl, output logic v, output logic b, output logic e);
    lb = 1'b0;
    drv_en = en;
    drv_dp = lvl;
    bit_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
    v = rx_valid;
    b = rx_bit;
    e = rx_stuff_err;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic v, b, e;
    int seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_oe && tx_dp && !tx_dm && !tx_ready, "R1", {tx_oe, tx_dp, tx_dm, tx_ready}, 4'b0100);
    chk(!rx_valid && !rx_stuff_err, "R1", {rx_valid, rx_stuff_err}, 0);

    // R6: five data ones plus sync's final one end on a stuffed zero
    n = 5; for (int i = 0; i < n; i++) d[i] = 1'b1;
    send_packet();
    // R4: long run of ones
    n = 14; for (int i = 0; i < n; i++) d[i] = 1'b1;
    send_packet();
    // R2: all zeros
    n = 10; for (int i = 0; i < n; i++) d[i] = 1'b0;
    send_packet();
    // single bit
    n = 1; d[0] = 1'b0;
    send_packet();
    // random packets weighted to ones
    for (int k = 0; k < 24; k++) begin
      n = 1 + int'($urandom % 40);
      for (int i = 0; i < n; i++) d[i] = (($urandom % 4) != 0);
      send_packet();
    end

    // Receive path driven directly
    rx_slot(1'b0, 1'b1, v, b, e);
    rx_slot(1'b1, 1'b0, v, b, e);
    chk(v && !b, "R9", {v, b}, 2'b10);
    for (int i = 0; i < 6; i++) begin
      rx_slot(1'b1, 1'b0, v, b, e);
      chk(v && b, "R9", {v, b}, 2'b11);
    end
    rx_slot(1'b1, 1'b1, v, b, e);
    chk(!v && !e, "R10", {v, e}, 0);
    for (int i = 0; i < 6; i++) begin
      rx_slot(1'b1, 1'b1, v, b, e);
      chk(v && b, "R9", {v, b}, 2'b11);
    end
    rx_slot(1'b1, 1'b1, v, b, e);
    chk(e && !v, "R11", {v, e}, 2'b01);
    rx_slot(1'b1, 1'b0, v, b, e);
    chk(v && !b && !e, "R11", {v, b, e}, 3'b100);
    rx_slot(1'b0, 1'b0, v, b, e);
    chk(!v && !e, "R12", {v, e}, 0);
    rx_slot(1'b1, 1'b1, v, b, e);
    chk(v && b, "R12", {v, b}, 2'b11);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule